// File: doc/BRIEF.md
# Line-Adaptive Variable-Period PWM Timebase

This block is the switching timebase for a boost power-factor-correction stage. It steps a counter through one switching period and drives the gate output high for the first part of each period, as set by a duty-compare value. The period length is not fixed. The period is recomputed from the most recent rectified line-voltage sample, so the switching rate rises as the line nears its zero crossing and falls as the line nears its crest.

The period is a programmable bias plus a scaled copy of the line sample. The bias is the period for the highest switching frequency. The scale factor sets how much the period stretches from zero line to full-scale line. The result is clamped between programmable lower and upper limits, and is never below two counts. A new period and a new compare value are loaded only when the counter wraps, so a running period is never cut short or stretched. A one-clock pulse marks the first clock of every period.

For example, a 120 MHz clock with a bias of 1500 and a scale of 1500 sweeps the switching rate from 80 kHz at zero line down to about 40 kHz at full-scale line.

Top module: `line_pwm_timebase`

## Requirements
- R1: While reset is high and in the first clock after it, `pwm_out` and `cycle_start` are low. The first period after reset lasts `RESET_PERIOD` clocks (default 1500), with `pwm_out` low throughout.
- R2: The computed period equals `bias_period + floor(line_sample * span_scale / 4096)`, with `line_sample` an unsigned 12-bit value in which 4095 is full scale.
- R3: A zero line sample gives the shortest period. A full-scale sample gives the longest period. An intermediate sample gives a period in between.
- R4: `line_sample` is captured only in a clock where `line_valid` is high. A change of `line_sample` while `line_valid` is low leaves the period unchanged.
- R5: A computed period above `limit_hi` is replaced by `limit_hi`.
- R6: A computed period below `limit_lo` is replaced by `limit_lo`, and the lower limit wins when the two limits cross. A period below 2 is forced to 2.
- R7: In each period, `pwm_out` is high for the first min(compare, period) clocks and low for the rest. A compare value of 0 keeps it low for the whole period.
- R8: `cycle_start` is high for exactly one clock, the first clock of each period.
- R9: Changes to the line sample or to `duty_cmp` in the middle of a period change neither that period's length nor its high time. They take effect from the next period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sample | input | SAMPLE_W (12) | Rectified line-voltage sample, unsigned |
| line_valid | input | 1 | Strobe that captures `line_sample` |
| duty_cmp | input | CNT_W (16) | Duty-compare value in clocks |
| bias_period | input | CNT_W (16) | Period at zero line (maximum-frequency period) |
| span_scale | input | SCALE_W (16) | Added period at full-scale line |
| limit_lo | input | CNT_W (16) | Lower period limit |
| limit_hi | input | CNT_W (16) | Upper period limit |
| pwm_out | output | 1 | Registered gate PWM output |
| cycle_start | output | 1 | One-clock pulse in the first clock of each period |

## Verification
The hardest case to create is a line sample or compare value that changes in the middle of a running period. A new value passes through the capture register and the period pipeline and then waits for the wrap, so if the stimulus is placed wrongly it lands on a boundary and tests nothing. The bench starts timing at a period-start pulse, counts three clocks into the period, and then drives a full-scale sample and a new compare value. It checks that the current period keeps its old length and high time, and that the period after it uses the new values. The limit-crossing and two-count floor cases need the bias, scale and limits set against each other, so a dedicated scenario reprograms them together.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;
  // Smallest period the counter supports: one clock high, one clock low.
  localparam int unsigned PERIOD_FLOOR = 2;
  // Fixed-point fraction bits of the line sample (full scale = 2**FRAC_BITS).
  localparam int unsigned FRAC_BITS    = 12;
endpackage

// File: rtl/lpwm_sample_hold.sv
module lpwm_sample_hold #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                sample_vld,
  output logic [SAMPLE_W-1:0] sample_q
);
  always_ff @(posedge clk) begin
    if (rst)             sample_q <= '0;
    else if (sample_vld) sample_q <= sample_in;
  end
endmodule

// File: rtl/lpwm_period_calc.sv
module lpwm_period_calc
  import lpwm_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 12,
  parameter int unsigned SCALE_W      = 16,
  parameter int unsigned CNT_W        = 16,
  parameter bit          REG_PRODUCT  = 1'b1,
  parameter int unsigned RESET_PERIOD = 1500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sample_q,
  input  logic [SCALE_W-1:0]  scale,
  input  logic [CNT_W-1:0]    bias,
  input  logic [CNT_W-1:0]    lim_lo,
  input  logic [CNT_W-1:0]    lim_hi,
  output logic [CNT_W-1:0]    period_q
);
  localparam int unsigned PROD_W = SAMPLE_W + SCALE_W;
  localparam int unsigned TERM_W = PROD_W - FRAC_BITS;
  localparam int unsigned WIDE_W = ((TERM_W > CNT_W) ? TERM_W : CNT_W) + 1;

  logic [PROD_W-1:0] prod_c;
  logic [PROD_W-1:0] prod_s;
  logic [TERM_W-1:0] term;
  logic [WIDE_W-1:0] raw, hi_x, lo_x, cap_hi, cap_lo, floored;

  assign prod_c = PROD_W'(sample_q) * PROD_W'(scale);

  // Optional pipeline stage after the multiplier, picked by parameter.
  generate
    if (REG_PRODUCT) begin : g_prod_reg
      always_ff @(posedge clk) begin
        if (rst) prod_s <= '0;
        else     prod_s <= prod_c;
      end
    end else begin : g_prod_comb
      assign prod_s = prod_c;
    end
  endgenerate

  assign term = prod_s[PROD_W-1:FRAC_BITS];

  always_comb begin
    raw     = WIDE_W'(bias) + WIDE_W'(term);
    hi_x    = WIDE_W'(lim_hi);
    lo_x    = WIDE_W'(lim_lo);
    cap_hi  = (raw > hi_x) ? hi_x : raw;
    cap_lo  = (cap_hi < lo_x) ? lo_x : cap_hi;
    floored = (cap_lo < WIDE_W'(PERIOD_FLOOR)) ? WIDE_W'(PERIOD_FLOOR) : cap_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) period_q <= CNT_W'(RESET_PERIOD);
    else     period_q <= floored[CNT_W-1:0];
  end
endmodule

// File: rtl/lpwm_counter.sv
module lpwm_counter #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned RESET_PERIOD = 1500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_next,
  input  logic [CNT_W-1:0] cmp_next,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             pwm,
  output logic             start
);
  logic             wrap;
  logic [CNT_W-1:0] cnt_inc;

  assign wrap    = (cnt == per_act - CNT_W'(1));
  assign cnt_inc = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_act <= CNT_W'(RESET_PERIOD);
      cmp_act <= '0;
      pwm     <= 1'b0;
      start   <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      per_act <= period_next;
      cmp_act <= cmp_next;
      pwm     <= (cmp_next != '0);
      start   <= 1'b1;
    end else begin
      cnt     <= cnt_inc;
      pwm     <= (cnt_inc < cmp_act);
      start   <= 1'b0;
    end
  end
endmodule

// File: rtl/line_pwm_timebase.sv
module line_pwm_timebase #(
  parameter int unsigned SAMPLE_W     = 12,
  parameter int unsigned SCALE_W      = 16,
  parameter int unsigned CNT_W        = 16,
  parameter bit          REG_PRODUCT  = 1'b1,
  parameter int unsigned RESET_PERIOD = 1500
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] line_sample,
  input  logic                line_valid,
  input  logic [CNT_W-1:0]    duty_cmp,
  input  logic [CNT_W-1:0]    bias_period,
  input  logic [SCALE_W-1:0]  span_scale,
  input  logic [CNT_W-1:0]    limit_lo,
  input  logic [CNT_W-1:0]    limit_hi,
  output logic                pwm_out,
  output logic                cycle_start
);
  logic [SAMPLE_W-1:0] samp_w;
  logic [CNT_W-1:0]    per_next_w, cnt_w, per_act_w, cmp_act_w;

  lpwm_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk(clk), .rst(rst), .sample_in(line_sample),
    .sample_vld(line_valid), .sample_q(samp_w)
  );

  lpwm_period_calc #(
    .SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W),
    .REG_PRODUCT(REG_PRODUCT), .RESET_PERIOD(RESET_PERIOD)
  ) u_calc (
    .clk(clk), .rst(rst), .sample_q(samp_w), .scale(span_scale),
    .bias(bias_period), .lim_lo(limit_lo), .lim_hi(limit_hi),
    .period_q(per_next_w)
  );

  lpwm_counter #(.CNT_W(CNT_W), .RESET_PERIOD(RESET_PERIOD)) u_cnt (
    .clk(clk), .rst(rst), .period_next(per_next_w), .cmp_next(duty_cmp),
    .cnt(cnt_w), .per_act(per_act_w), .cmp_act(cmp_act_w),
    .pwm(pwm_out), .start(cycle_start)
  );
endmodule

// File: rtl/line_pwm_timebase_chk.sv
module line_pwm_timebase_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] cmp_act,
  input logic             pwm_out,
  input logic             cycle_start
);
  a_r8_start_after_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == per_act - CNT_W'(1)) |=> cycle_start);

  a_r8_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> (cnt == '0));

  a_r9_period_held: assert property (@(posedge clk) disable iff (rst)
    !cycle_start |-> $stable(per_act));

  a_r6_period_floor: assert property (@(posedge clk) disable iff (rst)
    per_act >= CNT_W'(2));

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt < per_act);

  a_r7_zero_cmp_low: assert property (@(posedge clk) disable iff (rst)
    (cmp_act == '0) |-> !pwm_out);

  a_r7_full_cmp_high: assert property (@(posedge clk) disable iff (rst)
    (cmp_act >= per_act) |-> pwm_out);
endmodule

bind line_pwm_timebase line_pwm_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_w), .per_act(per_act_w),
  .cmp_act(cmp_act_w), .pwm_out(pwm_out), .cycle_start(cycle_start)
);

// File: tb/test_line_pwm_timebase.sv
`timescale 1ns/1ps
module test_line_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] line_sample = '0;
  logic        line_valid = 1'b0;
  logic [15:0] duty_cmp = 16'd10;
  logic [15:0] bias_period = 16'd20;
  logic [15:0] span_scale = 16'd40;
  logic [15:0] limit_lo = 16'd2;
  logic [15:0] limit_hi = 16'd1000;
  logic        pwm_out, cycle_start;
  int          checks = 0;
  int          fails  = 0;

  always #4 clk = ~clk;

  line_pwm_timebase i_line_pwm_timebase (
    .clk(clk), .rst(rst), .line_sample(line_sample), .line_valid(line_valid),
    .duty_cmp(duty_cmp), .bias_period(bias_period), .span_scale(span_scale),
    .limit_lo(limit_lo), .limit_hi(limit_hi),
    .pwm_out(pwm_out), .cycle_start(cycle_start)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(int s, int sc, int b, int lo, int hi);
    int p = b + (s * sc) / 4096;
    if (p > hi) p = hi;
    if (p < lo) p = lo;
    if (p < 2)  p = 2;
    return p;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic load_sample(input int s);
    @(negedge clk);
    line_sample = 12'(s);
    line_valid  = 1'b1;
    @(negedge clk);
    line_valid  = 1'b0;
  endtask

  // Measure one full period starting at a cycle_start pulse.
  task automatic measure(output int len, output int highs);
    len = 0; highs = 0;
    do @(negedge clk); while (!cycle_start);
    do begin
      highs += int'(pwm_out);
      len++;
      @(negedge clk);
    end while (!cycle_start);
  endtask

  task automatic settle_measure(output int len, output int highs);
    repeat (5) @(negedge clk);
    measure(len, highs);
  endtask

  task automatic t_reset();
    int n = 0, hi = 0;
    @(negedge clk);
    check("R1 pwm in reset", int'(pwm_out), 0);
    check("R1 start in reset", int'(cycle_start), 0);
    rst = 1'b0;
    while (!cycle_start) begin
      hi += int'(pwm_out);
      n++;
      @(negedge clk);
    end
    check("R1 first period length", n, 1500);
    check("R1 first period high time", hi, 0);
  endtask

  task automatic t_period(input int s, input string req);
    int len, hi, e;
    load_sample(s);
    settle_measure(len, hi);
    e = exp_period(s, int'(span_scale), int'(bias_period), int'(limit_lo), int'(limit_hi));
    check(req, len, e);
    check("R7 high time", hi, min2(int'(duty_cmp), e));
  endtask

  task automatic t_sweep();
    int l0, l1, l2, h;
    load_sample(0);    settle_measure(l0, h);
    load_sample(2048); settle_measure(l1, h);
    load_sample(4095); settle_measure(l2, h);
    check("R3 zero shorter than mid", int'(l0 < l1), 1);
    check("R3 mid shorter than peak", int'(l1 < l2), 1);
    check("R2 peak period", l2, 59);
  endtask

  task automatic t_ignore();
    int len, hi;
    load_sample(1000);
    @(negedge clk);
    line_sample = 12'd4095;   // no strobe
    settle_measure(len, hi);
    check("R4 unstrobed sample ignored", len, 29);
  endtask

  task automatic t_clamp_hi();
    int len, hi;
    limit_hi = 16'd30;
    load_sample(4095);
    settle_measure(len, hi);
    check("R5 upper clamp", len, 30);
    limit_hi = 16'd1000;
  endtask

  task automatic t_clamp_lo();
    int len, hi;
    limit_lo = 16'd50;
    load_sample(0);
    settle_measure(len, hi);
    check("R6 lower clamp", len, 50);
    limit_hi = 16'd30;
    settle_measure(len, hi);
    check("R6 lower limit wins when crossed", len, 50);
    limit_lo = 16'd2; limit_hi = 16'd1000;
  endtask

  task automatic t_floor();
    int len, hi;
    bias_period = 16'd0; span_scale = 16'd0; limit_lo = 16'd0;
    duty_cmp = 16'd1;
    settle_measure(len, hi);
    check("R6 two-count floor", len, 2);
    check("R7 one high clock at floor", hi, 1);
    bias_period = 16'd20; span_scale = 16'd40; limit_lo = 16'd2;
    duty_cmp = 16'd10;
  endtask

  task automatic t_duty();
    int len, hi;
    load_sample(0);
    duty_cmp = 16'd0;
    settle_measure(len, hi);
    check("R7 zero compare stays low", hi, 0);
    duty_cmp = 16'd200;
    settle_measure(len, hi);
    check("R7 compare above period stays high", hi, 20);
    duty_cmp = 16'd7;
    settle_measure(len, hi);
    check("R7 partial duty", hi, 7);
    duty_cmp = 16'd10;
  endtask

  task automatic t_start_pulse();
    do @(negedge clk); while (!cycle_start);
    @(negedge clk);
    check("R8 start pulse one clock", int'(cycle_start), 0);
  endtask

  task automatic t_midperiod();
    int len = 0, hi = 0, l2, h2;
    load_sample(0);
    duty_cmp = 16'd10;
    repeat (5) @(negedge clk);
    do @(negedge clk); while (!cycle_start);
    do begin
      hi += int'(pwm_out);
      len++;
      if (len == 3) begin
        line_sample = 12'd4095; line_valid = 1'b1; duty_cmp = 16'd15;
      end else begin
        line_valid = 1'b0;
      end
      @(negedge clk);
    end while (!cycle_start);
    line_valid = 1'b0;
    check("R9 running period length kept", len, 20);
    check("R9 running high time kept", hi, 10);
    len = 0;
    do begin
      h2 = int'(pwm_out); hi = (len == 0) ? h2 : hi + h2;
      len++;
      @(negedge clk);
    end while (!cycle_start);
    l2 = len;
    check("R9 next period uses new sample", l2, 59);
    check("R9 next period uses new compare", hi, 15);
    duty_cmp = 16'd10;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_period(0, "R2 zero-line period");
    t_period(1000, "R2 partial-line period");
    t_sweep();
    t_ignore();
    t_clamp_hi();
    t_clamp_lo();
    t_floor();
    t_duty();
    t_start_pulse();
    t_midperiod();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule